// File: doc/BRIEF.md
# Fixed-OR Array Logic

This block is a synthesizable model of a programmable array-logic device. The AND plane takes every array input in both its true and complemented form. A loadable connection word picks the literals that each AND term uses. The OR plane is fixed: every output owns seven sum terms and one enable term, and no term is shared between outputs. The sum then passes through an XOR with a per-output inversion bit. Ten dedicated inputs and six of the eight outputs feed the array. A fed-back output can therefore serve as a helper term for another output, one evaluation later.

Configuration is written one term at a time, as a parallel word, while the program-mode input is high. The block never drives pins itself. It presents registered output data together with a per-output enable for the pad ring to use. It takes the external pin value back on `padIn` for any fed-back output whose driver is switched off.

Top module: `orArrayLogic`

## Requirements
- R1: Reset clears every inversion bit and sets every connection bit, so each term evaluates to 0. In the cycle after reset, `outEn` and `outData` are all zero, and they stay zero until the device is programmed.
- R2: While `progMode` is high, a `cfgWr` pulse at address a below 64 stores `cfgData` as the connection word of term a, where a = output*8 + k. Slots k=0..6 are sum terms and k=7 is the enable term. Address 64 stores the inversion bits from `cfgData[7:0]`, with bit o belonging to output o.
- R3: In a connection word, bit 2j connects the true form of array input j and bit 2j+1 connects its complement. Array inputs 0..9 are `dataIn[9:0]`, and array inputs 10..15 are the feedback of outputs 1..6.
- R4: An AND term is the AND of its connected literals. A term with no connections evaluates to 1. A term that connects both a literal and its complement evaluates to 0.
- R5: The data of output o is the OR of its own seven sum terms only, XORed with inversion bit o.
- R6: When the enable term of output o is 0, `outEn[o]` is 0 and `outData[o]` is 0.
- R7: The feedback of an enabled output is its registered data. The feedback of a disabled output is the matching `padIn` bit (`padIn[i]` belongs to output i+1).
- R8: `outData` and `outEn` are registered. They update on each rising edge from the inputs and feedback present before that edge, so each pass through the array takes one cycle.
- R9: On every rising edge where `progMode` is high, all outputs become disabled with zero data.
- R10: A write with `progMode` low, or to an address above 64, changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| progMode | input | 1 | Program mode; writes are accepted and outputs are held off while it is high |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Term index (0..63) or inversion word (64) |
| cfgData | input | 32 | Connection word or inversion bits |
| dataIn | input | 10 | Dedicated array inputs |
| padIn | input | 6 | External pin values for fed-back outputs 1..6 |
| outData | output | 8 | Registered output data, zero when disabled |
| outEn | output | 8 | Registered per-output drive enable |

## Verification
A fixed program gives the outputs distinct roles:
- an AND of two inputs;
- an inverted OR;
- a contradictory term;
- an unprogrammed output;
- a constant;
- a seven-term OR;
- two outputs with conditional enables that are chained through feedback.

Input patterns that each set a single line show which slot of the seven-term OR listens to which input. They also show that the eighth input is left out of that OR. Patterns that toggle the enables of the chained outputs, with `padIn` at both extremes, separate reading the registered value from reading the external pin.

A step change on the chain, checked edge by edge, measures the one-cycle delay per pass. Writes with program mode low, and writes to an address above 64 that aliases a live term, must leave the outputs unchanged.

// File: rtl/orArrayPkg.sv
package orArrayPkg;
  localparam int OA_NUM_IN    = 10;
  localparam int OA_NUM_OUT   = 8;
  localparam int OA_SUM_TERMS = 7;
  localparam int OA_NUM_FB    = 6;
  localparam int OA_FB_BASE   = 1;

  typedef struct packed {
    logic wrTerm;   // store one connection word
    logic wrPol;    // store the inversion bits
    logic holdOff;  // force outputs disabled
  } oaStrobe_t;
endpackage

// File: rtl/orArrayCtrl.sv
module orArrayCtrl
  import orArrayPkg::*;
#(
  parameter int NUM_TERMS = 64,
  parameter int ADDR_W    = 7
) (
  input  logic              progMode,
  input  logic              cfgWr,
  input  logic [ADDR_W-1:0] cfgAddr,
  output oaStrobe_t         strobe
);
  logic termRange;
  logic polHit;

  always_comb begin
    termRange      = cfgAddr < ADDR_W'(NUM_TERMS);
    polHit         = cfgAddr == ADDR_W'(NUM_TERMS);
    strobe.wrTerm  = progMode & cfgWr & termRange;
    strobe.wrPol   = progMode & cfgWr & polHit;
    strobe.holdOff = progMode;
  end
endmodule

// File: rtl/orArrayCell.sv
module orArrayCell #(
  parameter int LIT_W     = 32,
  parameter int SUM_TERMS = 7
) (
  input  logic [LIT_W-1:0]              lits,
  input  logic [SUM_TERMS:0][LIT_W-1:0] termCfg,
  input  logic                          invert,
  output logic                          sumOut,
  output logic                          enOut
);
  logic [SUM_TERMS:0] termVal;

  // a term is 1 unless a connected literal is 0
  for (genvar k = 0; k <= SUM_TERMS; k++) begin : g_term
    assign termVal[k] = &(~termCfg[k] | lits);
  end

  assign sumOut = (|termVal[SUM_TERMS-1:0]) ^ invert;
  assign enOut  = termVal[SUM_TERMS];
endmodule

// File: rtl/orArrayDatapath.sv
module orArrayDatapath
  import orArrayPkg::*;
#(
  parameter int NUM_IN    = OA_NUM_IN,
  parameter int NUM_OUT   = OA_NUM_OUT,
  parameter int SUM_TERMS = OA_SUM_TERMS,
  parameter int NUM_FB    = OA_NUM_FB,
  parameter int FB_BASE   = OA_FB_BASE,
  localparam int TPO       = SUM_TERMS + 1,
  localparam int NUM_TERMS = NUM_OUT * TPO,
  localparam int ARRAY_IN  = NUM_IN + NUM_FB,
  localparam int LIT_W     = 2 * ARRAY_IN,
  localparam int ADDR_W    = $clog2(NUM_TERMS + 1),
  localparam int TERM_W    = $clog2(NUM_TERMS)
) (
  input  logic               clk,
  input  logic               rst,
  input  oaStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [LIT_W-1:0]   cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_FB-1:0]  padIn,
  output logic [NUM_OUT-1:0] outData,
  output logic [NUM_OUT-1:0] outEn
);
  logic [NUM_TERMS-1:0][LIT_W-1:0] fuseMap;
  logic [NUM_OUT-1:0]              invMap;
  logic [NUM_FB-1:0]               fbVal;
  logic [ARRAY_IN-1:0]             arrIn;
  logic [LIT_W-1:0]                lits;
  logic [NUM_OUT-1:0]              sumNext;
  logic [NUM_OUT-1:0]              enNext;

  // configuration store: blank means every literal connected
  always_ff @(posedge clk) begin
    if (rst) begin
      fuseMap <= '1;
      invMap  <= '0;
    end else begin
      if (strobe.wrTerm) fuseMap[cfgAddr[TERM_W-1:0]] <= cfgData;
      if (strobe.wrPol)  invMap <= cfgData[NUM_OUT-1:0];
    end
  end

  // feedback taken from the driven value or from the pin
  for (genvar i = 0; i < NUM_FB; i++) begin : g_fb
    assign fbVal[i] = outEn[FB_BASE+i] ? outData[FB_BASE+i] : padIn[i];
  end

  assign arrIn = {fbVal, dataIn};

  for (genvar j = 0; j < ARRAY_IN; j++) begin : g_lit
    assign lits[2*j]   = arrIn[j];
    assign lits[2*j+1] = ~arrIn[j];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_cell
    orArrayCell #(
      .LIT_W    (LIT_W),
      .SUM_TERMS(SUM_TERMS)
    ) u_cell (
      .lits   (lits),
      .termCfg(fuseMap[o*TPO +: TPO]),
      .invert (invMap[o]),
      .sumOut (sumNext[o]),
      .enOut  (enNext[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.holdOff) begin
      outEn   <= '0;
      outData <= '0;
    end else begin
      outEn   <= enNext;
      outData <= enNext & sumNext;
    end
  end
endmodule

// File: rtl/orArrayLogic.sv
module orArrayLogic
  import orArrayPkg::*;
#(
  parameter int NUM_IN    = OA_NUM_IN,
  parameter int NUM_OUT   = OA_NUM_OUT,
  parameter int SUM_TERMS = OA_SUM_TERMS,
  parameter int NUM_FB    = OA_NUM_FB,
  parameter int FB_BASE   = OA_FB_BASE,
  localparam int NUM_TERMS = NUM_OUT * (SUM_TERMS + 1),
  localparam int LIT_W     = 2 * (NUM_IN + NUM_FB),
  localparam int ADDR_W    = $clog2(NUM_TERMS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progMode,
  input  logic               cfgWr,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [LIT_W-1:0]   cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_FB-1:0]  padIn,
  output logic [NUM_OUT-1:0] outData,
  output logic [NUM_OUT-1:0] outEn
);
  oaStrobe_t ctrlStrobe;

  orArrayCtrl #(
    .NUM_TERMS(NUM_TERMS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .progMode(progMode),
    .cfgWr   (cfgWr),
    .cfgAddr (cfgAddr),
    .strobe  (ctrlStrobe)
  );

  orArrayDatapath #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .SUM_TERMS(SUM_TERMS),
    .NUM_FB   (NUM_FB),
    .FB_BASE  (FB_BASE)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctrlStrobe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .dataIn (dataIn),
    .padIn  (padIn),
    .outData(outData),
    .outEn  (outEn)
  );
endmodule

// File: rtl/orArrayLogicChk.sv
module orArrayLogicChk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               progMode,
  input logic               wrTerm,
  input logic               wrPol,
  input logic [NUM_OUT-1:0] outData,
  input logic [NUM_OUT-1:0] outEn
);
  // R1: reset leaves every output off
  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (outEn == '0 && outData == '0));

  // R9: program mode holds outputs off
  p_prog_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    progMode |=> (outEn == '0 && outData == '0));

  // R6: no data on a disabled output
  p_idle_data_r6: assert property (@(posedge clk) disable iff (rst)
    (outData & ~outEn) == '0);

  // R10: configuration strobes only in program mode
  p_write_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (wrTerm || wrPol) |-> progMode);

  // R2: one address selects at most one target
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wrTerm, wrPol}));
endmodule

bind orArrayLogic orArrayLogicChk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .progMode(progMode),
  .wrTerm  (ctrlStrobe.wrTerm),
  .wrPol   (ctrlStrobe.wrPol),
  .outData (outData),
  .outEn   (outEn)
);

// File: tb/sim_orArrayLogic.sv
module sim_orArrayLogic;
  logic        clk = 1'b0;
  logic        rst;
  logic        progMode;
  logic        cfgWr;
  logic [6:0]  cfgAddr;
  logic [31:0] cfgData;
  logic [9:0]  dataIn;
  logic [5:0]  padIn;
  logic [7:0]  outData;
  logic [7:0]  outEn;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  orArrayLogic u0 (
    .clk(clk), .rst(rst), .progMode(progMode), .cfgWr(cfgWr),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .dataIn(dataIn),
    .padIn(padIn), .outData(outData), .outEn(outEn)
  );

  // {dataIn, padIn, expected data, expected enables}
  typedef struct packed {
    logic [9:0] vin;
    logic [5:0] vpad;
    logic [7:0] expD;
    logic [7:0] expE;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{10'h000, 6'h00, 8'h42, 8'hDB},  // R4 R5: idle, inverted OR high
    '{10'h000, 6'h02, 8'h4A, 8'hDB},  // R7: pin value used for off output 2
    '{10'h003, 6'h00, 8'hC3, 8'hDB},  // R5: AND of in0,in1; OR slot 0
    '{10'h204, 6'h3F, 8'hC0, 8'hDF},  // R7: enabled output 2 wins over pin
    '{10'h200, 6'h3F, 8'h4E, 8'hDF},  // R7: chained feedback high
    '{10'h300, 6'h00, 8'h46, 8'hD7},  // R6: output 3 disabled by in8
    '{10'h040, 6'h00, 8'hC2, 8'hDB},  // R5 R3: OR slot 6 from in6
    '{10'h028, 6'h02, 8'hC8, 8'hDB},  // R5: in3 clears inverted OR
    '{10'h080, 6'h00, 8'h42, 8'hDB}   // R5 R3: in7 is outside the OR
  };

  task automatic checkOut(input logic [7:0] expD, input logic [7:0] expE,
                          input string tag);
    nChecks++;
    if (outData !== expD || outEn !== expE) begin
      nFail++;
      $display("FAIL %s: data=%h en=%h expected data=%h en=%h",
               tag, outData, outEn, expD, expE);
    end
  endtask

  task automatic cfgWrite(input logic [6:0] a, input logic [31:0] d);
    cfgAddr = a;
    cfgData = d;
    cfgWr   = 1'b1;
    @(negedge clk);
    cfgWr   = 1'b0;
  endtask

  task automatic applyHold(input logic [9:0] vin, input logic [5:0] vpad);
    dataIn = vin;
    padIn  = vpad;
    repeat (4) @(negedge clk);
  endtask

  task automatic programAll;
    progMode = 1'b1;
    cfgWrite(7'd0,  32'h0000_0005);   // out0 AND in0 in1
    cfgWrite(7'd7,  32'h0000_0000);   // out0 always enabled
    cfgWrite(7'd8,  32'h0000_0010);   // out1 in2
    cfgWrite(7'd9,  32'h0000_0040);   // out1 in3
    cfgWrite(7'd15, 32'h0000_0000);
    cfgWrite(7'd16, 32'h0010_0000);   // out2 feedback of out1
    cfgWrite(7'd23, 32'h0004_0000);   // out2 enabled by in9
    cfgWrite(7'd24, 32'h0040_0000);   // out3 feedback of out2
    cfgWrite(7'd31, 32'h0002_0000);   // out3 enabled by not in8
    cfgWrite(7'd32, 32'h0000_0003);   // out4 contradictory term
    cfgWrite(7'd39, 32'h0000_0000);
    cfgWrite(7'd55, 32'h0000_0000);   // out6 enabled, no sum terms
    for (int k = 0; k < 7; k++) cfgWrite(7'(56 + k), 32'(1) << (2 * k));
    cfgWrite(7'd63, 32'h0000_0000);
    cfgWrite(7'd64, 32'h0000_0042);   // invert out1 and out6
    progMode = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; progMode = 1'b0; cfgWr = 1'b0;
    cfgAddr = '0; cfgData = '0; dataIn = '0; padIn = '0;
    repeat (3) @(negedge clk);
    checkOut(8'h00, 8'h00, "R1 reset state");
    rst = 1'b0;
    applyHold(10'h3FF, 6'h3F);
    checkOut(8'h00, 8'h00, "R1 R4 blank device stays off");

    programAll();

    for (int v = 0; v < NVEC; v++) begin
      applyHold(VECS[v].vin, VECS[v].vpad);
      checkOut(VECS[v].expD, VECS[v].expE, $sformatf("R5 R7 vector %0d", v));
    end

    // R8: one cycle per pass through the feedback chain
    applyHold(10'h204, 6'h3F);
    dataIn = 10'h200;
    @(negedge clk);
    checkOut(8'h42, 8'hDF, "R8 first pass");
    @(negedge clk);
    checkOut(8'h46, 8'hDF, "R8 second pass");
    @(negedge clk);
    checkOut(8'h4E, 8'hDF, "R8 third pass");

    // R9: program mode forces outputs off, then they resume
    progMode = 1'b1;
    @(negedge clk);
    checkOut(8'h00, 8'h00, "R9 held off in program mode");
    progMode = 1'b0;
    repeat (4) @(negedge clk);
    checkOut(8'h4E, 8'hDF, "R9 resumes after program mode");

    // R10: writes outside program mode and beyond address 64 are ignored
    cfgWrite(7'd7,  32'hFFFF_FFFF);
    cfgWrite(7'd64, 32'h0000_00FF);
    progMode = 1'b1;
    cfgWrite(7'd71, 32'hFFFF_FFFF);
    progMode = 1'b0;
    applyHold(10'h003, 6'h00);
    checkOut(8'hC3, 8'hDB, "R10 R2 ignored writes");

    // R1: reset mid-run wipes the program
    rst = 1'b1;
    @(negedge clk);
    checkOut(8'h00, 8'h00, "R1 reset during run");
    rst = 1'b0;
    applyHold(10'h003, 6'h00);
    checkOut(8'h00, 8'h00, "R1 program cleared by reset");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule